// File: doc/BRIEF.md
# Control-Indexed Mux-Tree Barrel Shifter

A purely combinational shifter and rotator for a data word of `WIDTH` bits (16 by default, down to 4). A control word selects the operation. Its low bits give an amount from 0 to `WIDTH-1`, the next bit chooses shift (0) or rotate (1), and the top bit chooses left (0) or right (1). The result appears at the output in the same evaluation as the inputs. No clock and no state are involved.

Each output bit is produced by its own balanced tree of 2:1 mux cells. The full control word indexes the tree directly, so the leaves enumerate every operation: 64 leaves per bit at width 16. The leaves are fixed wires from the data word or from one fill signal. A single shared 2:1 mux cell, steered by the direction bit, makes that fill: 0 when going left, the data MSB when going right. The default build has 16 × 63 tree cells plus the fill cell, which is 1009 cells in all. The worst path is seven cell levels.

Top module: `bsh_barrel`

## Requirements
- R1: When the amount field is 0, `data_o` equals `data_i` in all four operations.
- R2: Left shift (ctrl bit 5 = 0, bit 4 = 0) by k gives `data_i << k`, with the vacated low bits set to 0.
- R3: Right shift (bit 5 = 1, bit 4 = 0) by k is arithmetic: the vacated high bits take a copy of `data_i[WIDTH-1]`.
- R4: Left rotate (bit 5 = 0, bit 4 = 1) by k moves input bit i to output bit (i+k) mod WIDTH.
- R5: Right rotate (bit 5 = 1, bit 4 = 1) by k gives output bit i equal to input bit (i+k) mod WIDTH.
- R6: The control fields sit at fixed positions: amount in `ctrl_i[3:0]`, type in `ctrl_i[4]`, direction in `ctrl_i[5]`. For example, data 16'h8421 with ctrl 6'h04, 6'h24, 6'h14 and 6'h34 gives 16'h4210, 16'hF842, 16'h4218 and 16'h1842.
- R7: The fill value affects shifts only. Rotations never insert fill, so a rotation keeps the number of set bits.
- R8: The block has no storage: `data_o` follows a change of `data_i` or `ctrl_i` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Operand word |
| ctrl_i | input | $clog2(WIDTH)+2 | {direction, type, amount} control word |
| data_o | output | WIDTH | Shifted or rotated result |

## Verification
The checker compares the output against operator-level formulas. It assumes the data and control inputs are fully known two-state values that have settled, and it assumes `WIDTH` is a power of two, so every amount value is a legal distance. The bench only drives defined values. It changes the inputs half a clock phase before it looks at the output. It runs all 64 control codes over corner words and random words, so every leaf of every tree is selected at least once.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_ROL = 2'b01,
    OP_SHR = 2'b10,
    OP_ROR = 2'b11
  } op_e;

  function automatic int unsigned ctrl_width(int unsigned w);
    return $clog2(w) + 2;
  endfunction
endpackage

// File: rtl/bsh_mux2.sv
module bsh_mux2 (
  input  logic d0_i,
  input  logic d1_i,
  input  logic s_i,
  output logic y_o
);
  assign y_o = s_i ? d1_i : d0_i;
endmodule

// File: rtl/bsh_mux_tree.sv
// Balanced 2^SEL_W:1 mux tree held as a heap; root selects with the MSB.
module bsh_mux_tree #(
  parameter int unsigned SEL_W = 6,
  localparam int unsigned N_LEAF = 2 ** SEL_W
) (
  input  logic [N_LEAF-1:0] leaf_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              y_o
);
  logic [2*N_LEAF-2:0] heap;

  assign heap[N_LEAF-1 +: N_LEAF] = leaf_i;

  for (genvar m = 0; m < N_LEAF - 1; m++) begin : g_node
    localparam int unsigned DEPTH = $clog2(m + 2) - 1;
    bsh_mux2 u_cell (
      .d0_i(heap[2*m+1]),
      .d1_i(heap[2*m+2]),
      .s_i (sel_i[SEL_W-1-DEPTH]),
      .y_o (heap[m])
    );
  end

  assign y_o = heap[0];
endmodule

// File: rtl/bsh_leaf_map.sv
// Wires each tree leaf to the data bit or fill that its control code selects.
module bsh_leaf_map
  import bsh_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CTRL_W = ctrl_width(WIDTH),
  localparam int unsigned N_LEAF = 2 ** CTRL_W
) (
  input  logic [WIDTH-1:0]        data_i,
  input  logic                    fill_i,
  output logic [WIDTH*N_LEAF-1:0] leaf_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    for (genvar j = 0; j < N_LEAF; j++) begin : g_leaf
      localparam int AMT = j % WIDTH;
      localparam op_e OP = op_e'(j / WIDTH);
      localparam int UP = i + AMT;
      localparam int DN = i - AMT;
      if (OP == OP_SHL) begin : g_shl
        if (DN >= 0) begin : g_src
          assign leaf_o[i*N_LEAF+j] = data_i[DN];
        end else begin : g_fill
          assign leaf_o[i*N_LEAF+j] = fill_i;
        end
      end else if (OP == OP_ROL) begin : g_rol
        assign leaf_o[i*N_LEAF+j] = data_i[(DN + WIDTH) % WIDTH];
      end else if (OP == OP_SHR) begin : g_shr
        if (UP < WIDTH) begin : g_src
          assign leaf_o[i*N_LEAF+j] = data_i[UP];
        end else begin : g_fill
          assign leaf_o[i*N_LEAF+j] = fill_i;
        end
      end else begin : g_ror
        assign leaf_o[i*N_LEAF+j] = data_i[UP % WIDTH];
      end
    end
  end
endmodule

// File: rtl/bsh_barrel.sv
module bsh_barrel
  import bsh_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CTRL_W = ctrl_width(WIDTH),
  localparam int unsigned N_LEAF = 2 ** CTRL_W
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  data_o
);
  logic                    fill;
  logic [WIDTH*N_LEAF-1:0] leaf;

  // shared fill cell: 0 going left, MSB going right
  bsh_mux2 u_fill (
    .d0_i(1'b0),
    .d1_i(data_i[WIDTH-1]),
    .s_i (ctrl_i[CTRL_W-1]),
    .y_o (fill)
  );

  bsh_leaf_map #(.WIDTH(WIDTH)) u_map (
    .data_i(data_i),
    .fill_i(fill),
    .leaf_o(leaf)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    bsh_mux_tree #(.SEL_W(CTRL_W)) u_tree (
      .leaf_i(leaf[i*N_LEAF +: N_LEAF]),
      .sel_i (ctrl_i),
      .y_o   (data_o[i])
    );
  end
endmodule

// File: rtl/bsh_barrel_chk.sv
module bsh_barrel_chk #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CTRL_W = $clog2(WIDTH) + 2,
  localparam int unsigned AMT_W = CTRL_W - 2
) (
  input logic [WIDTH-1:0]  data_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [WIDTH-1:0]  data_o
);
  logic [AMT_W-1:0]   amt;
  logic               rot;
  logic               dir;
  logic [2*WIDTH-1:0] dbl_l;
  logic [2*WIDTH-1:0] dbl_r;

  assign amt   = ctrl_i[AMT_W-1:0];
  assign rot   = ctrl_i[AMT_W];
  assign dir   = ctrl_i[AMT_W+1];
  assign dbl_l = {data_i, data_i} << amt;
  assign dbl_r = {data_i, data_i} >> amt;

  always_comb begin
    p_zero_pass_r1: assert (amt != '0 || data_o == data_i)
      else $error("zero amount altered data");
    p_shl_r2: assert (rot || dir || data_o == (data_i << amt))
      else $error("left shift mismatch");
    p_shr_r3: assert (rot || !dir || data_o == WIDTH'($signed(data_i) >>> amt))
      else $error("arithmetic right shift mismatch");
    p_rol_r4: assert (!rot || dir || data_o == dbl_l[2*WIDTH-1:WIDTH])
      else $error("left rotate mismatch");
    p_ror_r5: assert (!rot || !dir || data_o == dbl_r[WIDTH-1:0])
      else $error("right rotate mismatch");
    p_rot_pop_r7: assert (!rot || $countones(data_o) == $countones(data_i))
      else $error("rotation changed bit count");
  end
endmodule

bind bsh_barrel bsh_barrel_chk #(.WIDTH(WIDTH)) u_chk (
  .data_i(data_i),
  .ctrl_i(ctrl_i),
  .data_o(data_o)
);

// File: tb/bsh_barrel_bench.sv
module bsh_barrel_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 16;
  localparam int unsigned CW = 6;
  localparam int unsigned WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  data;
  logic [CW-1:0] ctrl;
  logic [W-1:0]  res;
  int            n_tests = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsh_barrel #(.WIDTH(W)) u_bsh_barrel (
    .data_i(data),
    .ctrl_i(ctrl),
    .data_o(res)
  );

  function automatic logic [W-1:0] ref_op(logic [W-1:0] d, logic [CW-1:0] c);
    int unsigned k;
    logic [2*W-1:0] t;
    k = int'(c[3:0]);
    case (c[5:4])
      2'b00: return d << k;
      2'b01: begin t = {d, d} << k; return t[2*W-1:W]; end
      2'b10: return W'($signed(d) >>> k);
      default: begin t = {d, d} >> k; return t[W-1:0]; end
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s data=%h ctrl=%h act=%h exp=%h", req, data, ctrl, act, exp);
    end
  endtask

  task automatic sweep(logic [W-1:0] d);
    string req;
    for (int c = 0; c < 64; c++) begin
      @(posedge clk);
      data = d;
      ctrl = CW'(c);
      @(negedge clk);
      if (c % 16 == 0) req = "R1";
      else case (c / 16)
        0: req = "R2";
        1: req = "R4";
        2: req = "R3";
        default: req = "R5";
      endcase
      chk(req, res, ref_op(d, CW'(c)));
    end
  endtask

  task automatic apply(logic [W-1:0] d, logic [CW-1:0] c, string req, logic [W-1:0] exp);
    @(posedge clk);
    data = d;
    ctrl = c;
    @(negedge clk);
    chk(req, res, exp);
  endtask

  initial begin
    data = '0;
    ctrl = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", res, 16'h0000);

    // R6 fixed field positions
    apply(16'h8421, 6'h04, "R6", 16'h4210);
    apply(16'h8421, 6'h24, "R6", 16'hF842);
    apply(16'h8421, 6'h14, "R6", 16'h4218);
    apply(16'h8421, 6'h34, "R6", 16'h1842);

    // R7 fill only on shifts
    apply(16'h8000, 6'h2F, "R7", 16'hFFFF);
    apply(16'h7FFF, 6'h2F, "R7", 16'h0000);
    apply(16'hFFFF, 6'h0F, "R7", 16'h8000);
    apply(16'h8000, 6'h31, "R7", 16'h4000);
    apply(16'h0001, 6'h1F, "R7", 16'h8000);

    // R8 output follows inputs with no clock edge
    @(negedge clk);
    data = 16'h00F0;
    ctrl = 6'h02;
    #1 chk("R8", res, 16'h03C0);
    ctrl = 6'h22;
    #1 chk("R8", res, 16'h003C);

    sweep(16'h0000);
    sweep(16'hFFFF);
    sweep(16'h8000);
    sweep(16'h8001);
    sweep(16'hA5C3);
    for (int b = 0; b < W; b += 5) sweep(W'(1) << b);
    for (int r = 0; r < 16; r++) sweep(W'($urandom));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule